// File: doc/BRIEF.md
# Memory Operation Ordering Gate

The gate sits between an in-order producer of memory operations and a memory port that may finish them in any order. Each operation arrives over a valid/ready handshake with a 3-bit kind, an address and a tag chosen by the producer. Accepted operations go into an age-ordered window of outstanding entries. Each cycle the gate offers the memory port the oldest entry that the ordering rules allow to go out. Completions come back on a separate interface and name the tag.

The kinds are plain loads and stores, loads with acquire semantics, stores with release semantics, and four classes of fence. Each fence class has its own ordering mask. Fences never reach the memory port. A fence holds its window slot until its condition is met and then retires inside the gate. Entries leave the window from the oldest end, once they are finished. Even with no fence present, a load and a store to the same address keep their program order.

Top module: `og_order_gate`

## Requirements
- R1: The window holds DEPTH (8) entries. `in_ready` is low exactly when all of them are occupied. Entries are freed oldest first, once finished, so completing the oldest entry of a full window raises `in_ready` again.
- R2: Kind codes are 0 load, 1 store, 2 acquire-load, 3 release-store, 4 full fence, 5 store-order fence, 6 load-order fence, 7 light fence. Plain loads and stores to distinct addresses issue one per accepted port handshake, oldest first, without waiting for earlier completions.
- R3: After a full fence (4), no later load or store issues until every earlier load and store has completed.
- R4: After a store-order fence (5), later stores wait until earlier stores complete. Later loads issue while earlier stores are still outstanding.
- R5: After a load-order fence (6), later loads wait until earlier loads complete. Later stores issue while earlier loads are still outstanding.
- R6: After a light fence (7), later stores wait for every earlier load and store. A later load waits only for earlier loads, so it may issue while an earlier store is outstanding.
- R7: An acquire-load (2) may issue while older operations are outstanding. No younger operation issues until the acquire-load has completed.
- R8: A release-store (3) issues only after every older load and store has completed. Younger operations may issue before it. It is presented with `mem_kind` 3.
- R9: A load never issues while an older store to the same address is incomplete, and a store never issues while an older load to the same address is incomplete.
- R10: Fences are never presented on the memory port. A fence keeps its window slot until its ordering condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The window has a free slot |
| in_kind | input | 3 | Operation kind code |
| in_addr | input | ADDR_W | Operation address |
| in_tag | input | TAG_W | Producer tag, echoed on issue and completion |
| mem_valid | output | 1 | An operation is offered to the memory port |
| mem_ready | input | 1 | The memory port takes the offered operation |
| mem_kind | output | 3 | Kind of the offered operation (0 to 3) |
| mem_addr | output | ADDR_W | Address of the offered operation |
| mem_tag | output | TAG_W | Tag of the offered operation |
| cpl_valid | input | 1 | An issued operation has completed |
| cpl_tag | input | TAG_W | Tag of the completed operation |

## Verification
The assertions assume the producer keeps tags unique among the operations in the window. They also assume the memory side returns exactly one completion per issued operation and never returns a tag that is not outstanding. Under these assumptions the window occupancy, the issued count and the completed count can be tracked from the handshakes alone. Each directed scenario starts from reset and uses a fresh set of tags. It completes only tags it has already seen issued, one per cycle, and keeps the number of offered operations within the window depth, so no stimulus leaves these assumptions.

// File: rtl/og_pkg.sv
package og_pkg;

    typedef enum logic [2:0] {
        OP_LD    = 3'd0,
        OP_ST    = 3'd1,
        OP_ACQ   = 3'd2,
        OP_REL   = 3'd3,
        OP_FFULL = 3'd4,
        OP_FST   = 3'd5,
        OP_FLD   = 3'd6,
        OP_FLW   = 3'd7
    } op_kind_e;

    function automatic logic is_load(logic [2:0] k);
        return (k == OP_LD) || (k == OP_ACQ);
    endfunction

    function automatic logic is_store(logic [2:0] k);
        return (k == OP_ST) || (k == OP_REL);
    endfunction

endpackage

// File: rtl/og_order_rules.sv
// Ordering rules evaluated over the window in age order (index 0 is oldest).
module og_order_rules
    import og_pkg::*;
#(
    parameter int N      = 8,
    parameter int ADDR_W = 16
) (
    input  logic [N-1:0]             live,
    input  logic [N-1:0]             issued,
    input  logic [N-1:0]             done,
    input  logic [N-1:0][2:0]        kind,
    input  logic [N-1:0][ADDR_W-1:0] addr,
    output logic [N-1:0]             issue_ok,
    output logic [N-1:0]             fence_ok
);

    always_comb begin
        logic [N-1:0] ld_before;
        logic pend_ld, pend_st, blk_ld, blk_st, blk_acq, clash, me_ld, me_st;
        ld_before = '0;
        issue_ok  = '0;
        fence_ok  = '0;
        for (int i = 0; i < N; i++) begin
            pend_ld = 1'b0;
            pend_st = 1'b0;
            blk_ld  = 1'b0;
            blk_st  = 1'b0;
            blk_acq = 1'b0;
            clash   = 1'b0;
            me_ld   = is_load(kind[i]);
            me_st   = is_store(kind[i]);
            for (int j = 0; j < i; j++) begin
                if (live[j] && !done[j]) begin
                    if (is_load(kind[j]))  pend_ld = 1'b1;
                    if (is_store(kind[j])) pend_st = 1'b1;
                    case (kind[j])
                        OP_ACQ:   blk_acq = 1'b1;
                        OP_FFULL: begin blk_ld = 1'b1; blk_st = 1'b1; end
                        OP_FST:   blk_st = 1'b1;
                        OP_FLD:   blk_ld = 1'b1;
                        OP_FLW:   begin
                            blk_st = 1'b1;
                            if (ld_before[j]) blk_ld = 1'b1;
                        end
                        default:  ;
                    endcase
                    if ((addr[j] == addr[i]) &&
                        ((me_ld && is_store(kind[j])) || (me_st && is_load(kind[j]))))
                        clash = 1'b1;
                end
            end
            ld_before[i] = pend_ld;

            issue_ok[i] = live[i] && !issued[i] && (me_ld || me_st) && !blk_acq &&
                          !(me_ld && blk_ld) && !(me_st && blk_st) && !clash &&
                          !((kind[i] == OP_REL) && (pend_ld || pend_st));

            if (kind[i] == OP_FFULL || kind[i] == OP_FLW)
                fence_ok[i] = !pend_ld && !pend_st;
            else if (kind[i] == OP_FST)
                fence_ok[i] = !pend_st;
            else if (kind[i] == OP_FLD)
                fence_ok[i] = !pend_ld;
            else
                fence_ok[i] = 1'b0;
            fence_ok[i] = fence_ok[i] && live[i] && !done[i] && !blk_acq;
        end
    end

endmodule

// File: rtl/og_oldest_pick.sv
// Chooses the lowest age index among the requesters.
module og_oldest_pick #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                any = 1'b1;
                idx = IW'(k);
            end
        end
    end

endmodule

// File: rtl/og_order_gate.sv
module og_order_gate
    import og_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_kind,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [2:0]        mem_kind,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [TAG_W-1:0]  mem_tag,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    typedef struct packed {
        logic [DEPTH-1:0]             live;
        logic [DEPTH-1:0]             issued;
        logic [DEPTH-1:0]             done;
        logic [DEPTH-1:0][2:0]        kind;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [PW-1:0]                head;
        logic [PW-1:0]                tail;
        logic [CW-1:0]                count;
    } state_t;

    state_t q, d;

    // Age-ordered view of the ring
    logic [DEPTH-1:0]             a_live, a_issued, a_done;
    logic [DEPTH-1:0][2:0]        a_kind;
    logic [DEPTH-1:0][ADDR_W-1:0] a_addr;
    logic [DEPTH-1:0][TAG_W-1:0]  a_tag;
    logic [DEPTH-1:0][PW-1:0]     a_slot;

    for (genvar p = 0; p < DEPTH; p++) begin : g_age
        assign a_slot[p]   = q.head + PW'(p);
        assign a_live[p]   = CW'(p) < q.count;
        assign a_issued[p] = q.issued[a_slot[p]];
        assign a_done[p]   = q.done[a_slot[p]];
        assign a_kind[p]   = q.kind[a_slot[p]];
        assign a_addr[p]   = q.addr[a_slot[p]];
        assign a_tag[p]    = q.tag[a_slot[p]];
    end

    logic [DEPTH-1:0] issue_ok, fence_ok;
    logic             pick_any;
    logic [PW-1:0]    pick_age;

    og_order_rules #(.N(DEPTH), .ADDR_W(ADDR_W)) u_rules (
        .live     (a_live),
        .issued   (a_issued),
        .done     (a_done),
        .kind     (a_kind),
        .addr     (a_addr),
        .issue_ok (issue_ok),
        .fence_ok (fence_ok)
    );

    og_oldest_pick #(.N(DEPTH)) u_pick (
        .req (issue_ok),
        .any (pick_any),
        .idx (pick_age)
    );

    logic acc, retire;

    assign in_ready  = q.count != CW'(DEPTH);
    assign acc       = in_valid && in_ready;
    assign retire    = q.live[q.head] && q.done[q.head];
    assign mem_valid = pick_any;
    assign mem_kind  = a_kind[pick_age];
    assign mem_addr  = a_addr[pick_age];
    assign mem_tag   = a_tag[pick_age];

    always_comb begin
        d = q;
        if (acc) begin
            d.live[q.tail]   = 1'b1;
            d.issued[q.tail] = 1'b0;
            d.done[q.tail]   = 1'b0;
            d.kind[q.tail]   = in_kind;
            d.addr[q.tail]   = in_addr;
            d.tag[q.tail]    = in_tag;
            d.tail           = q.tail + PW'(1);
        end
        if (mem_valid && mem_ready)
            d.issued[a_slot[pick_age]] = 1'b1;
        if (cpl_valid) begin
            for (int s = 0; s < DEPTH; s++) begin
                if (q.live[s] && q.issued[s] && !q.done[s] && (q.tag[s] == cpl_tag))
                    d.done[s] = 1'b1;
            end
        end
        for (int p = 0; p < DEPTH; p++) begin
            if (fence_ok[p])
                d.done[a_slot[p]] = 1'b1;
        end
        if (retire) begin
            d.live[q.head] = 1'b0;
            d.head         = q.head + PW'(1);
        end
        d.count = q.count + CW'(acc) - CW'(retire);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/og_order_gate_chk.sv
module og_order_gate_chk #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH) + 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [2:0] in_kind,
    input logic       mem_valid,
    input logic       mem_ready,
    input logic       cpl_valid,
    input logic       retire_pulse
);

    logic [CW-1:0] occ;       // accepted minus freed
    logic [CW-1:0] to_issue;  // accepted memory operations not yet issued
    logic [CW-1:0] in_flight; // issued but not completed

    logic take, fire;
    assign take = in_valid && in_ready;
    assign fire = mem_valid && mem_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ       <= '0;
            to_issue  <= '0;
            in_flight <= '0;
        end else begin
            occ       <= occ + CW'(take) - CW'(retire_pulse);
            to_issue  <= to_issue + CW'(take && !in_kind[2]) - CW'(fire);
            in_flight <= in_flight + CW'(fire) - CW'(cpl_valid);
        end
    end

    p_ready_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (occ != CW'(DEPTH)));

    p_free_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        retire_pulse |-> (occ != '0));

    p_in_flight_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight <= CW'(DEPTH));

    p_cpl_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (in_flight != '0));

    p_memop_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (to_issue != '0));

endmodule

bind og_order_gate og_order_gate_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_kind      (in_kind),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .cpl_valid    (cpl_valid),
    .retire_pulse (retire)
);

// File: tb/sim_og_order_gate.sv
`timescale 1ns/1ps
module sim_og_order_gate;

    localparam int AW = 16;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [2:0]    in_kind = '0;
    logic [AW-1:0] in_addr = '0;
    logic [TW-1:0] in_tag = '0;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic [2:0]    mem_kind;
    logic [AW-1:0] mem_addr;
    logic [TW-1:0] mem_tag;
    logic          cpl_valid = 1'b0;
    logic [TW-1:0] cpl_tag = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    og_order_gate #(.DEPTH(8), .ADDR_W(AW), .TAG_W(TW)) u0 (
        .clk, .rst_n, .in_valid, .in_ready, .in_kind, .in_addr, .in_tag,
        .mem_valid, .mem_ready, .mem_kind, .mem_addr, .mem_tag,
        .cpl_valid, .cpl_tag
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL R1 watchdog: actual %0d cycles expected below 20000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0; mem_ready = 1'b0; cpl_valid = 1'b0;
        settle(2);
        rst_n = 1'b1;
        settle(1);
    endtask

    task automatic push(input logic [2:0] k, input logic [AW-1:0] a, input logic [TW-1:0] t);
        in_valid = 1'b1; in_kind = k; in_addr = a; in_tag = t;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_issue(input logic [TW-1:0] t, input string req);
        settle(2);
        check(mem_valid && mem_tag == t, req, {mem_valid, mem_tag}, {1'b1, t});
        if (mem_valid) begin
            mem_ready = 1'b1;
            @(negedge clk);
            mem_ready = 1'b0;
        end
    endtask

    task automatic expect_idle(input string req);
        settle(2);
        check(!mem_valid, req, mem_valid, 0);
    endtask

    task automatic complete(input logic [TW-1:0] t);
        cpl_valid = 1'b1; cpl_tag = t;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check(in_ready == 1'b1, "R1", in_ready, 1);
        check(mem_valid == 1'b0, "R10", mem_valid, 0);
    endtask

    task automatic t_plain();
        do_reset();
        push(3'd0, 16'h10, 4'd1);
        push(3'd1, 16'h20, 4'd2);
        push(3'd0, 16'h30, 4'd3);
        expect_issue(4'd1, "R2");
        expect_issue(4'd2, "R2");
        expect_issue(4'd3, "R2");
        complete(4'd3); complete(4'd1); complete(4'd2);
    endtask

    task automatic t_full_fence();
        do_reset();
        push(3'd1, 16'h11, 4'd1);
        push(3'd4, 16'h00, 4'd2);
        push(3'd0, 16'h15, 4'd3);
        expect_issue(4'd1, "R3");
        expect_idle("R3");
        complete(4'd1);
        expect_issue(4'd3, "R3");   // fence tag 2 never offered: R10
        complete(4'd3);
    endtask

    task automatic t_store_fence();
        do_reset();
        push(3'd1, 16'h11, 4'd1);
        push(3'd5, 16'h00, 4'd2);
        push(3'd0, 16'h12, 4'd3);
        push(3'd1, 16'h13, 4'd4);
        expect_issue(4'd1, "R4");
        expect_issue(4'd3, "R4");
        expect_idle("R4");
        complete(4'd1);
        expect_issue(4'd4, "R4");
        complete(4'd3); complete(4'd4);
    endtask

    task automatic t_load_fence();
        do_reset();
        push(3'd0, 16'h11, 4'd1);
        push(3'd6, 16'h00, 4'd2);
        push(3'd1, 16'h12, 4'd3);
        push(3'd0, 16'h13, 4'd4);
        expect_issue(4'd1, "R5");
        expect_issue(4'd3, "R5");
        expect_idle("R5");
        complete(4'd1);
        expect_issue(4'd4, "R5");
        complete(4'd3); complete(4'd4);
    endtask

    task automatic t_light_fence();
        do_reset();
        push(3'd1, 16'h11, 4'd1);
        push(3'd0, 16'h12, 4'd2);
        push(3'd7, 16'h00, 4'd3);
        push(3'd0, 16'h14, 4'd4);
        push(3'd1, 16'h15, 4'd5);
        expect_issue(4'd1, "R6");
        expect_issue(4'd2, "R6");
        expect_idle("R6");
        complete(4'd2);
        expect_issue(4'd4, "R6");
        expect_idle("R6");
        complete(4'd1);
        expect_issue(4'd5, "R6");
        complete(4'd4); complete(4'd5);
    endtask

    task automatic t_acquire();
        do_reset();
        push(3'd1, 16'h11, 4'd1);
        push(3'd2, 16'h12, 4'd2);
        push(3'd0, 16'h13, 4'd3);
        expect_issue(4'd1, "R7");
        settle(2);
        check(mem_kind == 3'd2, "R7", mem_kind, 2);
        expect_issue(4'd2, "R7");
        expect_idle("R7");
        complete(4'd2);
        expect_issue(4'd3, "R7");
        complete(4'd1); complete(4'd3);
    endtask

    task automatic t_release();
        do_reset();
        push(3'd0, 16'h11, 4'd1);
        push(3'd3, 16'h12, 4'd2);
        push(3'd0, 16'h13, 4'd3);
        expect_issue(4'd1, "R8");
        expect_issue(4'd3, "R8");
        expect_idle("R8");
        complete(4'd1);
        settle(2);
        check(mem_kind == 3'd3, "R8", mem_kind, 3);
        expect_issue(4'd2, "R8");
        complete(4'd2); complete(4'd3);
    endtask

    task automatic t_same_addr();
        do_reset();
        push(3'd1, 16'h77, 4'd1);
        push(3'd0, 16'h77, 4'd2);
        push(3'd0, 16'h78, 4'd3);
        expect_issue(4'd1, "R9");
        expect_issue(4'd3, "R9");
        expect_idle("R9");
        complete(4'd1);
        expect_issue(4'd2, "R9");
        complete(4'd2); complete(4'd3);
    endtask

    task automatic t_full_window();
        do_reset();
        for (int i = 0; i < 8; i++) push(3'd0, AW'(16'h100 + i), TW'(i));
        check(in_ready == 1'b0, "R1", in_ready, 0);
        expect_issue(4'd0, "R1");
        complete(4'd0);
        settle(2);
        check(in_ready == 1'b1, "R1", in_ready, 1);
    endtask

    task automatic t_fence_slot();
        do_reset();
        for (int i = 0; i < 7; i++) push(3'd1, AW'(16'h200 + i), TW'(i));
        push(3'd4, 16'h0, 4'd9);
        settle(2);
        check(in_ready == 1'b0, "R10", in_ready, 0);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_full_fence();
        t_store_fence();
        t_load_fence();
        t_light_fence();
        t_acquire();
        t_release();
        t_same_addr();
        t_full_window();
        t_fence_slot();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule